// File: doc/BRIEF.md
# Write-Once Countdown Register

This block holds a 17-bit count that is given its starting value once and can afterwards only be lowered, one step per command, down to a floor of zero where it stays. Until the one-time load has happened the register is inactive: it holds zero, reports itself as not set, and turns away decrement commands. The count and the set flag stand for nonvolatile cells. They carry a blank power-up value through declaration initialisers and are not cleared by the block's reset, so a reset restores only the control state around them.

Every command that changes the cells starts a write window of a programmable number of cycles, during which further load or decrement commands are refused. Any refused command raises a one-cycle reject pulse. A read strobe is always honoured. One cycle later it produces a marker pulse, together with a snapshot of the count taken at the strobe, so that a downstream signing stage can pick up the value it must authenticate.

Top module: `wdc_counter`

## Requirements
- R1: On a blank part after reset, set_o is 0, count_o is 0, and busy_o, rej_o, auth_o and empty_o are all 0.
- R2: A load strobe sampled while set_o is 0 and busy_o is 0 writes ld_val to count_o and raises set_o, both visible in the cycle after the strobe.
- R3: An accepted decrement lowers count_o by exactly one in the cycle after the strobe.
- R4: empty_o is 1 exactly when set_o is 1 and count_o is 0. A decrement sampled in that state is rejected and count_o stays 0.
- R5: A decrement sampled while set_o is 0 is rejected, and count_o and set_o keep their values.
- R6: A load strobe sampled while set_o is 1 is rejected and leaves count_o unchanged.
- R7: rej_o is high for exactly one cycle, the cycle after any rejected command, and is low after every accepted command.
- R8: When load and decrement strobes are sampled together, only the load is evaluated. If it is accepted, count_o equals ld_val (not ld_val minus one). If it is refused, count_o is unchanged.
- R9: After each accepted command busy_o is high for exactly WR_CYCLES consecutive cycles, starting in the cycle after the strobe. A load or decrement sampled while busy_o is 1 is rejected and has no effect on count_o.
- R10: A read strobe is never rejected and never changes count_o, including while busy_o is 1. In the next cycle auth_o is high for one cycle and sig_cnt_o holds the value count_o had when the strobe was sampled.
- R11: Reset clears busy_o, rej_o and auth_o, but count_o and set_o keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the control state |
| ld_stb | input | 1 | One-time load command |
| ld_val | input | 17 | Starting value for the load |
| dec_stb | input | 1 | Decrement command |
| rd_stb | input | 1 | Authenticated read request |
| count_o | output | 17 | Current count |
| set_o | output | 1 | Starting value has been written |
| empty_o | output | 1 | Set and count is zero |
| busy_o | output | 1 | Write window in progress |
| rej_o | output | 1 | One-cycle pulse for a refused command |
| auth_o | output | 1 | One-cycle marker for a read result |
| sig_cnt_o | output | 17 | Count captured by the last read |

## Verification
The assertions assume that strobes are sampled only on clock edges and that the cells start from their blank initial value rather than from an arbitrary state. They also assume that WR_CYCLES is at least one, so that every accepted write is followed by a busy cycle. The directed stimulus changes inputs only on falling clock edges and starts from the blank part. It never sends a load whose value leaves the 17-bit range, and it uses the default write window, whose length the bench counts cycle by cycle.

// File: rtl/wdc_pkg.sv
package wdc_pkg;

    localparam int CNT_W_DEF = 17;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_LOAD = 2'd1,
        OP_DEC  = 2'd2
    } wdc_op_e;

    typedef struct packed {
        wdc_op_e op;
        logic    reject;
    } wdc_verdict_t;

    // Judge one cycle's command: load outranks decrement, busy blocks all writes.
    function automatic wdc_verdict_t judge(input logic ld, input logic dec,
                                           input logic is_set, input logic at_zero,
                                           input logic busy);
        wdc_verdict_t v;
        v.op     = OP_NONE;
        v.reject = 1'b0;
        if (ld) begin
            if (busy || is_set) v.reject = 1'b1;
            else                v.op     = OP_LOAD;
        end else if (dec) begin
            if (busy || !is_set || at_zero) v.reject = 1'b1;
            else                            v.op     = OP_DEC;
        end
        return v;
    endfunction

endpackage

// File: rtl/wdc_decode.sv
module wdc_decode
    import wdc_pkg::*;
(
    input  logic         ld_stb,
    input  logic         dec_stb,
    input  logic         is_set,
    input  logic         at_zero,
    input  logic         busy,
    output wdc_verdict_t verdict
);
    always_comb begin
        verdict = judge(ld_stb, dec_stb, is_set, at_zero, busy);
    end

    always_comb begin
        if (ld_stb) assert (verdict.op != OP_DEC)
            else $error("p_load_wins_r8: decrement chosen while load present");
    end
endmodule

// File: rtl/wdc_wtimer.sv
module wdc_wtimer #(
    parameter int WR_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int TW = $clog2(WR_CYCLES + 1);
    localparam logic [TW-1:0] TLOAD = TW'(WR_CYCLES);

    logic [TW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)                 left_q <= '0;
        else if (start)          left_q <= TLOAD;
        else if (left_q != '0)   left_q <= left_q - 1'b1;
    end

    assign busy = (left_q != '0);

    p_window_r9: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);
endmodule

// File: rtl/wdc_store.sv
module wdc_store
    import wdc_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  wdc_op_e          op,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt,
    output logic             is_set
);
    // Retained cells: blank initial value, untouched by the block reset.
    logic [CNT_W-1:0] cnt_q = '0;
    logic             set_q = 1'b0;

    always_ff @(posedge clk) begin
        case (op)
            OP_LOAD: begin
                cnt_q <= ld_val;
                set_q <= 1'b1;
            end
            OP_DEC:  cnt_q <= cnt_q - 1'b1;
            default: ;
        endcase
    end

    assign cnt    = cnt_q;
    assign is_set = set_q;

    p_set_sticky_r6: assert property (@(posedge clk)
        set_q |=> set_q);
endmodule

// File: rtl/wdc_rdport.sv
module wdc_rdport #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_stb,
    input  logic [CNT_W-1:0] cnt,
    output logic             auth,
    output logic [CNT_W-1:0] snap
);
    always_ff @(posedge clk) begin
        if (rst) begin
            auth <= 1'b0;
            snap <= '0;
        end else begin
            auth <= rd_stb;
            if (rd_stb) snap <= cnt;
        end
    end

    p_snap_r10: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> auth && (snap == $past(cnt)));
endmodule

// File: rtl/wdc_counter.sv
module wdc_counter
    import wdc_pkg::*;
#(
    parameter int CNT_W     = CNT_W_DEF,
    parameter int WR_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_stb,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             dec_stb,
    input  logic             rd_stb,
    output logic [CNT_W-1:0] count_o,
    output logic             set_o,
    output logic             empty_o,
    output logic             busy_o,
    output logic             rej_o,
    output logic             auth_o,
    output logic [CNT_W-1:0] sig_cnt_o
);
    wdc_verdict_t     verdict;
    logic [CNT_W-1:0] cnt;
    logic             is_set;
    logic             busy;
    logic             at_zero;
    logic             rej_q;

    assign at_zero = (cnt == '0);

    wdc_decode u_decode (
        .ld_stb  (ld_stb),
        .dec_stb (dec_stb),
        .is_set  (is_set),
        .at_zero (at_zero),
        .busy    (busy),
        .verdict (verdict)
    );

    wdc_store #(.CNT_W(CNT_W)) u_store (
        .clk    (clk),
        .op     (verdict.op),
        .ld_val (ld_val),
        .cnt    (cnt),
        .is_set (is_set)
    );

    wdc_wtimer #(.WR_CYCLES(WR_CYCLES)) u_wtimer (
        .clk   (clk),
        .rst   (rst),
        .start (verdict.op != OP_NONE),
        .busy  (busy)
    );

    wdc_rdport #(.CNT_W(CNT_W)) u_rdport (
        .clk    (clk),
        .rst    (rst),
        .rd_stb (rd_stb),
        .cnt    (cnt),
        .auth   (auth_o),
        .snap   (sig_cnt_o)
    );

    always_ff @(posedge clk) begin
        if (rst) rej_q <= 1'b0;
        else     rej_q <= verdict.reject;
    end

    assign count_o = cnt;
    assign set_o   = is_set;
    assign empty_o = is_set && at_zero;
    assign busy_o  = busy;
    assign rej_o   = rej_q;

    p_once_r6: assert property (@(posedge clk) disable iff (rst)
        (set_o && ld_stb) |=> $stable(count_o) && rej_o);

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        set_o |=> (count_o == $past(count_o)) || (count_o == $past(count_o) - 1'b1));

    p_floor_r4: assert property (@(posedge clk) disable iff (rst)
        (set_o && count_o == '0) |=> count_o == '0);

    p_unset_r5: assert property (@(posedge clk) disable iff (rst)
        (!set_o && !ld_stb) |=> !set_o && $stable(count_o));

    p_busy_block_r9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && (ld_stb || dec_stb)) |=> rej_o && $stable(count_o));
endmodule

// File: tb/wdc_counter_tb.sv
module wdc_counter_tb;
    localparam int CW = 17;
    localparam int WR = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_stb = 1'b0;
    logic [CW-1:0] ld_val = '0;
    logic          dec_stb = 1'b0;
    logic          rd_stb = 1'b0;
    logic [CW-1:0] count_o, sig_cnt_o;
    logic          set_o, empty_o, busy_o, rej_o, auth_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    wdc_counter #(.CNT_W(CW), .WR_CYCLES(WR)) u_dut (
        .clk(clk), .rst(rst), .ld_stb(ld_stb), .ld_val(ld_val),
        .dec_stb(dec_stb), .rd_stb(rd_stb), .count_o(count_o),
        .set_o(set_o), .empty_o(empty_o), .busy_o(busy_o), .rej_o(rej_o),
        .auth_o(auth_o), .sig_cnt_o(sig_cnt_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one cycle of strobes at a falling edge; return at the next falling edge.
    task automatic cmd(input bit ld, input int val, input bit dec, input bit rd);
        ld_stb = ld; ld_val = CW'(val); dec_stb = dec; rd_stb = rd;
        @(negedge clk);
        ld_stb = 0; dec_stb = 0; rd_stb = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20 && busy_o; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk); @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1", "set", set_o, 0);
        chk("R1", "count", count_o, 0);
        chk("R1", "busy", busy_o, 0);
        chk("R1", "rej", rej_o, 0);
        chk("R1", "auth", auth_o, 0);
        chk("R1", "empty", empty_o, 0);
    endtask

    task automatic t_dec_unset();
        cmd(0, 0, 1, 0);
        chk("R5", "rej", rej_o, 1);
        chk("R5", "set", set_o, 0);
        chk("R5", "count", count_o, 0);
        chk("R4", "empty unset", empty_o, 0);
        @(negedge clk);
        chk("R7", "rej one cycle", rej_o, 0);
    endtask

    task automatic t_read_unset();
        cmd(0, 0, 0, 1);
        chk("R10", "auth", auth_o, 1);
        chk("R10", "snap", sig_cnt_o, 0);
        chk("R10", "rej", rej_o, 0);
        @(negedge clk);
        chk("R10", "auth pulse", auth_o, 0);
    endtask

    task automatic t_load_with_dec();
        int busy_n;
        cmd(1, 3, 1, 0);
        chk("R8", "count", count_o, 3);
        chk("R2", "set", set_o, 1);
        chk("R7", "rej after accept", rej_o, 0);
        busy_n = busy_o ? 1 : 0;
        // decrement plus read while busy
        cmd(0, 0, 1, 1);
        chk("R9", "rej busy", rej_o, 1);
        chk("R9", "count busy", count_o, 3);
        chk("R10", "auth busy", auth_o, 1);
        chk("R10", "snap busy", sig_cnt_o, 3);
        if (busy_o) busy_n++;
        for (int i = 0; i < 20 && busy_o; i++) begin
            @(negedge clk);
            if (busy_o) busy_n++;
        end
        chk("R9", "busy length", busy_n, WR);
    endtask

    task automatic t_second_load();
        cmd(1, 9, 0, 0);
        chk("R6", "rej", rej_o, 1);
        chk("R6", "count", count_o, 3);
        chk("R6", "busy untouched", busy_o, 0);
    endtask

    task automatic t_countdown_and_reset();
        cmd(0, 0, 1, 0);
        chk("R3", "3->2", count_o, 2);
        chk("R3", "rej", rej_o, 0);
        chk("R9", "busy", busy_o, 1);
        rst = 1;
        @(negedge clk);
        rst = 0;
        chk("R11", "count kept", count_o, 2);
        chk("R11", "set kept", set_o, 1);
        chk("R11", "busy cleared", busy_o, 0);
        cmd(0, 0, 1, 0);
        chk("R3", "2->1", count_o, 1);
        cmd(0, 0, 0, 1);
        chk("R10", "read busy no rej", rej_o, 0);
        chk("R10", "snap", sig_cnt_o, 1);
        chk("R10", "count", count_o, 1);
        wait_idle();
        cmd(0, 0, 1, 0);
        chk("R3", "1->0", count_o, 0);
        chk("R4", "empty", empty_o, 1);
        wait_idle();
        cmd(0, 0, 1, 0);
        chk("R4", "rej at zero", rej_o, 1);
        chk("R4", "count floor", count_o, 0);
        chk("R4", "no busy", busy_o, 0);
    endtask

    task automatic t_both_when_set();
        cmd(1, 7, 1, 0);
        chk("R8", "rej", rej_o, 1);
        chk("R8", "count", count_o, 0);
        chk("R8", "set", set_o, 1);
    endtask

    initial begin
        t_reset();
        t_dec_unset();
        t_read_unset();
        t_load_with_dec();
        t_second_load();
        t_countdown_and_reset();
        t_both_when_set();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule